// File: doc/BRIEF.md
# Load-Use Stall Controller

This block is the hazard control for a five-stage pipeline that stalls once behind every load-word instruction. It reads the opcode field of each word as it is fetched and flags loads while they are still in the fetch stage. It does not compare registers against the next instruction. Every valid load that is accepted is followed by exactly one stall cycle.

In the stall cycle the block holds the program counter, blocks the IF/ID register so that no new instruction is taken in, and raises a strobe. That strobe tells the datapath to load an all-zero bubble into ID/EX. A taken-branch flush overrides the stall. If the flush comes in the same cycle as a load, no stall is armed. If it comes during the stall cycle, that stall is cancelled. Reset is synchronous and active-high.

Top module: `load_stall_ctl`

## Requirements
- R1: Reset is synchronous and active-high. It clears any pending stall, so the first cycle after reset shows pc_en=1, ifid_we=1 and bubble_ins=0.
- R2: A fetch with fetch_valid=1 and fetch_opcode=6'b100011 (the load) arms a stall. If no flush is present, the next cycle shows pc_en=0, ifid_we=0 and bubble_ins=1.
- R3: A stall lasts exactly one cycle. The cycle after a stall shows bubble_ins=0.
- R4: The opcodes 6'b001000 (add-immediate), 6'b000000 (set-less-than), 6'b000100 (branch-equal) and 6'b101011 (store) never cause a stall.
- R5: The fetch input is ignored during the stall cycle. A load opcode presented in that cycle causes no bubble in the following cycle.
- R6: A stream of back-to-back loads gives the fixed pattern load, bubble, load, bubble. A load fetched in the cycle after a stall arms its own stall.
- R7: A flush in the same cycle as a load fetch wins, and the next cycle shows no stall.
- R8: A flush during the stall cycle cancels that stall. In that cycle pc_en=1, ifid_we=1 and bubble_ins=0.
- R9: A load opcode with fetch_valid=0 causes no stall.
- R10: pc_en and ifid_we are always equal, and bubble_ins is their inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | The fetched word is a real instruction |
| fetch_opcode | input | 6 | Opcode field of the fetched word |
| branch_flush | input | 1 | Taken-branch flush |
| pc_en | output | 1 | Program counter advance enable |
| ifid_we | output | 1 | IF/ID register write enable |
| bubble_ins | output | 1 | Load an all-zero bubble into ID/EX |

## Verification
Streams of the four non-load opcodes show that only the load opcode arms a stall. Isolated loads, with ordinary words after them, show the one-cycle length of the stall. A load word held on the fetch input through the stall cycle tells the suppressed fetch apart from a second stall. Back-to-back load streams confirm the load, bubble, load, bubble cadence. Flushes placed on the load cycle and on the stall cycle, a reset during a stall, and loads marked invalid separate the override and gating paths from the normal arming path.

// File: rtl/ls_pkg.sv
package ls_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;

  // True when the opcode names a load that must be followed by one bubble.
  function automatic logic opc_is_load(input logic [OPC_W-1:0] opc);
    return opc == OPC_LOAD;
  endfunction

  // A stall is armed when a valid load arrives outside a stall and no flush is present.
  function automatic logic arm_rule(input logic hit, input logic stalled, input logic flush);
    return hit && !stalled && !flush;
  endfunction
endpackage

// File: rtl/ls_predecode.sv
module ls_predecode
  import ls_pkg::*;
#(
  parameter int W = OPC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] opcode,
  output logic         load_hit
);
  assign load_hit = valid && opc_is_load(opcode[OPC_W-1:0]);

  assert_invalid_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !load_hit);
endmodule

// File: rtl/ls_stall_seq.sv
module ls_stall_seq
  import ls_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_hit,
  input  logic flush,
  output logic stall_now
);
  logic stall_q;
  logic arm;

  assign arm       = arm_rule(load_hit, stall_q, flush);
  assign stall_now = stall_q && !flush;

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= arm;
  end

  assert_load_stalls_R2: assert property (@(posedge clk) disable iff (rst)
    (load_hit && !stall_q && !flush) |=> (stall_now || flush));
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    stall_now |=> !stall_now);
  assert_ignore_in_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (stall_q && load_hit) |=> !stall_q);
  assert_flush_prevents_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !stall_q);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !stall_q);
endmodule

// File: rtl/load_stall_ctl.sv
module load_stall_ctl
  import ls_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [OPC_W-1:0] fetch_opcode,
  input  logic             branch_flush,
  output logic             pc_en,
  output logic             ifid_we,
  output logic             bubble_ins
);
  logic load_hit;
  logic stall_now;

  ls_predecode #(.W(OPC_W)) u_pre (
    .clk(clk), .rst(rst), .valid(fetch_valid), .opcode(fetch_opcode), .load_hit(load_hit)
  );

  ls_stall_seq u_seq (
    .clk(clk), .rst(rst), .load_hit(load_hit), .flush(branch_flush), .stall_now(stall_now)
  );

  assign pc_en      = !stall_now;
  assign ifid_we    = !stall_now;
  assign bubble_ins = stall_now;

  assert_enables_agree_R10: assert property (@(posedge clk) disable iff (rst)
    (pc_en == ifid_we) && (bubble_ins != pc_en));
  assert_flush_cancels_R8: assert property (@(posedge clk) disable iff (rst)
    branch_flush |-> (pc_en && !bubble_ins));
  assert_no_bubble_after_reset_R1: assert property (@(posedge clk)
    rst |=> !bubble_ins);
endmodule

// File: tb/load_stall_ctl_tb_top.sv
module load_stall_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid = 1'b0;
  logic [5:0] fetch_opcode = 6'b000000;
  logic branch_flush = 1'b0;
  logic pc_en, ifid_we, bubble_ins;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pend_q[$];

  always #5 clk = ~clk;

  load_stall_ctl dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_opcode(fetch_opcode),
    .branch_flush(branch_flush), .pc_en(pc_en), .ifid_we(ifid_we), .bubble_ins(bubble_ins)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, compare against the model, then advance the model.
  task automatic step(input bit r, input bit v, input logic [5:0] opc, input bit fl, input string tag);
    bit stalled;
    bit exp_stall;
    bit accept;
    @(negedge clk);
    rst = r; fetch_valid = v; fetch_opcode = opc; branch_flush = fl;
    #2;
    stalled   = pend_q.size() > 0;
    exp_stall = stalled && !fl;
    chk(tag, "pc_en", int'(pc_en), int'(!exp_stall));
    chk(tag, "ifid_we", int'(ifid_we), int'(!exp_stall));
    chk(tag, "bubble_ins", int'(bubble_ins), int'(exp_stall));
    chk("R10", "pc_en==ifid_we", int'(pc_en == ifid_we), 1);
    accept = !r && v && (opc == 6'b100011) && !stalled && !fl;
    @(posedge clk);
    pend_q.delete();
    if (accept) pend_q.push_back(1);
  endtask

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, ADDI = 6'b001000,
                         BEQ = 6'b000100, SLT = 6'b000000;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, SLT, 0, "R1");
    step(1, 1, LW, 0, "R1");
    step(0, 0, SLT, 0, "R1");
    // R4: non-load opcodes
    step(0, 1, ADDI, 0, "R4");
    step(0, 1, SLT, 0, "R4");
    step(0, 1, BEQ, 0, "R4");
    step(0, 1, SW, 0, "R4");
    step(0, 1, SW, 0, "R4");
    // R2 and R3: isolated load
    step(0, 1, LW, 0, "R2");
    step(0, 1, ADDI, 0, "R2");
    step(0, 1, ADDI, 0, "R3");
    step(0, 1, SLT, 0, "R3");
    // R5: load word held during the stall cycle is ignored
    step(0, 1, LW, 0, "R5");
    step(0, 1, LW, 0, "R5");
    step(0, 1, SW, 0, "R5");
    // R6: back-to-back loads
    for (int i = 0; i < 6; i++) step(0, 1, LW, 0, "R6");
    step(0, 1, ADDI, 0, "R6");
    step(0, 1, ADDI, 0, "R6");
    // R7: flush with load fetch
    step(0, 1, LW, 1, "R7");
    step(0, 1, ADDI, 0, "R7");
    // R8: flush during stall cycle
    step(0, 1, LW, 0, "R8");
    step(0, 1, BEQ, 1, "R8");
    step(0, 1, ADDI, 0, "R8");
    // R9: invalid load
    step(0, 0, LW, 0, "R9");
    step(0, 0, LW, 0, "R9");
    step(0, 1, ADDI, 0, "R9");
    // R1: reset during a stall clears pending state
    step(0, 1, LW, 0, "R1");
    step(1, 1, LW, 0, "R1");
    step(0, 1, ADDI, 0, "R1");
    step(0, 1, ADDI, 0, "R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule